// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block sits beside a two-wire bus controller and watches the clock (SCL) and data (SDA) lines. It detects two timing conditions. The first is a clock-low timeout, where SCL is held low for longer than a programmed limit. The second is a bus-free condition, where both lines stay high for longer than the same limit divided by 512. Both durations are measured in ticks of a timeout clock. Software selects whether that clock runs at the full system clock or at the system clock divided by 64.

The block keeps a small 8-bit control and status register:

- Four plain control bits, which are stored and brought out for the surrounding controller to use.
- A sticky low-timeout flag, which software clears by writing 1.
- A bus-free flag that hardware sets and clears.

The 16-bit limit comes in as an input. A limit of zero turns off the clock-low detection.

Top module: `smb_timeout_mon`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, every register bit goes to 0, and `low_to_o` and `bus_free_o` go to 0.
- R2: A write (`wr_en`=1) loads `wr_data[7:4]` into `csr_o[7:4]`. The bits are: bit 7 fast-ACK enable, bit 6 alert-address enable, bit 5 second-address enable, bit 4 tick select. Bits 1:0 always read 0. Bit 2 ignores writes.
- R3: When tick select (bit 4) is 1, the timeout counters advance on every system clock. When it is 0, they advance once every 64 system clocks.
- R4: The low-timeout flag is `csr_o[3]` and is mirrored on `low_to_o`. It sets once SCL has stayed low for more than `limit_i` ticks.
- R5: When `limit_i` is 0, the low-timeout flag never sets, however long SCL stays low.
- R6: The low-timeout flag stays set after SCL returns high. Writing 0 to bit 3 leaves it set. Writing 1 to bit 3 clears it on the following cycle.
- R7: If a write of 1 to bit 3 lands while a low timeout is still being detected, the flag stays 1.
- R8: The bus-free flag is `csr_o[2]` and is mirrored on `bus_free_o`. It sets once SCL and SDA have both stayed high for more than `limit_i >> 9` ticks.
- R9: The bus-free flag clears within three system clocks after either line goes low. Software cannot write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| limit_i | input | 16 | Timeout limit in ticks; 0 disables the low timeout |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| csr_o | output | 8 | Control and status register contents |
| low_to_o | output | 1 | Low-timeout flag |
| bus_free_o | output | 1 | Bus-free flag |

## Verification
The assertions assume three things about the inputs:

- The bus lines pass through a two-stage synchronizer and a flag register, so a change at the pins reaches the flags exactly three clocks later.
- `limit_i` stays steady for as long as a duration is being measured.
- Any line level that matters lasts for at least one full clock.

The stimulus changes the lines and `limit_i` only on falling clock edges. It holds each level for many cycles. It changes the limit only while SCL is high, so the clock-low counter is idle when the limit moves. The bench checks each flag with a margin of several cycles around the threshold, which keeps the checks independent of the exact prescaler phase.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  localparam int B_FACK  = 7;
  localparam int B_ALERT = 6;
  localparam int B_ALT   = 5;
  localparam int B_FAST  = 4;
  localparam int B_LOWTO = 3;
  localparam int B_FREE  = 2;

  typedef struct packed {
    logic       fast_ack_en;
    logic       alert_en;
    logic       alt_addr_en;
    logic       tick_fast;
    logic       low_to;
    logic       bus_free;
    logic [1:0] rsvd;
  } csr_t;
endpackage

// File: rtl/smbto_sync.sv
module smbto_sync #(
  parameter int W      = 2,
  parameter bit RSTVAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RSTVAL;
        s2 <= RSTVAL;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/smbto_tick.sv
module smbto_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || pre == LAST) pre <= '0;
    else                    pre <= pre + 1'b1;
  end

  assign tick_o = fast_i | (pre == LAST);
endmodule

// File: rtl/smbto_span.sv
module smbto_span #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || !cond_i)               cnt_o <= '0;
    else if (tick_i && cnt_o != TOP)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/smb_timeout_mon.sv
module smb_timeout_mon
  import smbto_pkg::*;
#(
  parameter int LIMW   = 16,
  parameter int DIV    = 64,
  parameter int HSHIFT = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [LIMW-1:0] limit_i,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      csr_o,
  output logic            low_to_o,
  output logic            bus_free_o
);
  localparam int CW = LIMW + 1;

  csr_t          csr;
  logic [1:0]    line_s;
  logic          scl_s, sda_s, tick;
  logic [CW-1:0] lcnt, hcnt, lim_ext, thr_hi;
  logic          low_det, free_det;
  logic          unused_wr;

  assign unused_wr = ^wr_data[2:0];

  smbto_sync #(.W(2), .RSTVAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i({scl_in, sda_in}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smbto_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .fast_i(csr.tick_fast), .tick_o(tick)
  );

  smbto_span #(.CW(CW)) u_low (
    .clk(clk), .rst(rst), .cond_i(~scl_s), .tick_i(tick), .cnt_o(lcnt)
  );

  smbto_span #(.CW(CW)) u_high (
    .clk(clk), .rst(rst), .cond_i(scl_s & sda_s), .tick_i(tick), .cnt_o(hcnt)
  );

  assign lim_ext  = {1'b0, limit_i};
  assign thr_hi   = lim_ext >> HSHIFT;
  assign low_det  = ~scl_s & (limit_i != '0) & (lcnt > lim_ext);
  assign free_det = scl_s & sda_s & (hcnt > thr_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr <= '0;
    end else begin
      if (wr_en) begin
        csr.fast_ack_en <= wr_data[B_FACK];
        csr.alert_en    <= wr_data[B_ALERT];
        csr.alt_addr_en <= wr_data[B_ALT];
        csr.tick_fast   <= wr_data[B_FAST];
      end
      csr.low_to   <= low_det | (csr.low_to & ~(wr_en & wr_data[B_LOWTO]));
      csr.bus_free <= free_det;
      csr.rsvd     <= '0;
    end
  end

  assign csr_o      = csr;
  assign low_to_o   = csr.low_to;
  assign bus_free_o = csr.bus_free;
endmodule

// File: rtl/smb_timeout_mon_sva.sv
module smb_timeout_mon_sva #(
  parameter int LIMW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            scl_in,
  input logic            sda_in,
  input logic [LIMW-1:0] limit_i,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic [7:0]      csr_o,
  input logic            low_to_o,
  input logic            bus_free_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (csr_o == 8'h00 && !low_to_o && !bus_free_o));

  a_r2_ctl_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (csr_o[7:4] == $past(wr_data[7:4])));

  a_r5_zero_limit: assert property (@(posedge clk) disable iff (rst)
    (limit_i == '0 && !low_to_o) |=> !low_to_o);

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (low_to_o && !(wr_en && wr_data[3])) |=> low_to_o);

  a_r8_free_needs_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_free_o) |-> ($past(scl_in, 3) && $past(sda_in, 3)));

  a_r9_free_drop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 3) && (!$past(scl_in, 3) || !$past(sda_in, 3))) |-> !bus_free_o);
endmodule

bind smb_timeout_mon smb_timeout_mon_sva #(.LIMW(LIMW)) u_sva (.*);

// File: tb/smb_timeout_mon_bench.sv
`timescale 1ns/1ps
module smb_timeout_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_in = 1'b1, sda_in = 1'b1;
  logic [15:0] limit_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  csr_o;
  logic        low_to_o, bus_free_o;

  int applied = 0, miscmp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smb_timeout_mon u_smb_timeout_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .limit_i(limit_i),
    .wr_en(wr_en), .wr_data(wr_data), .csr_o(csr_o), .low_to_o(low_to_o),
    .bus_free_o(bus_free_o)
  );

  // entry: [29] tick select, [28:13] limit, [12:1] low hold cycles, [0] expected flag
  localparam logic [29:0] VEC [7] = '{
    {1'b1, 16'd20,   12'd10,   1'b0},
    {1'b1, 16'd20,   12'd40,   1'b1},
    {1'b1, 16'd0,    12'd300,  1'b0},
    {1'b0, 16'd3,    12'd100,  1'b0},
    {1'b0, 16'd3,    12'd400,  1'b1},
    {1'b1, 16'd1000, 12'd990,  1'b0},
    {1'b1, 16'd1000, 12'd1020, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wrap_up;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 csr after reset", csr_o, 8'h00);
    chk("R1 flags after reset", {6'b0, low_to_o, bus_free_o}, 8'h00);

    // R2: write all ones while SCL low and limit zero
    scl_in = 1'b0; idle(4);
    wr(8'hFF);
    chk("R2 write mask, bit2 ignored", csr_o, 8'hF0);
    wr(8'h10);
    scl_in = 1'b1; idle(5);

    // R3 / R4 / R5 table
    for (int i = 0; i < 7; i++) begin
      limit_i = VEC[i][28:13];
      wr({3'b000, VEC[i][29], 1'b1, 3'b000});
      idle(3);
      scl_in = 1'b0;
      idle(int'(VEC[i][12:1]));
      chk($sformatf("R3/R4/R5 vector %0d low flag", i), {7'b0, low_to_o}, {7'b0, VEC[i][0]});
      chk($sformatf("R4 vector %0d csr bit3", i), {7'b0, csr_o[3]}, {7'b0, VEC[i][0]});
      scl_in = 1'b1;
      idle(5);
    end

    // R6: sticky, write 0 no effect, write 1 clears
    limit_i = 16'd20;
    wr(8'h18); idle(3);
    scl_in = 1'b0; idle(40); scl_in = 1'b1; idle(10);
    chk("R6 flag sticky after release", {7'b0, low_to_o}, 8'h01);
    wr(8'h10);
    chk("R6 write 0 keeps flag", {7'b0, low_to_o}, 8'h01);
    wr(8'h18);
    chk("R6 write 1 clears flag", {7'b0, low_to_o}, 8'h00);

    // R7: set wins over clear
    scl_in = 1'b0; idle(40);
    wr(8'h18);
    chk("R7 set beats clear", {7'b0, low_to_o}, 8'h01);
    scl_in = 1'b1; idle(5);
    wr(8'h18);
    chk("R7 clear once released", {7'b0, low_to_o}, 8'h00);

    // R8: bus free, threshold 0x1400 >> 9 = 10 ticks
    limit_i = 16'h1400;
    scl_in = 1'b0; idle(4);
    scl_in = 1'b1; idle(5);
    chk("R8 not free too early", {7'b0, bus_free_o}, 8'h00);
    idle(25);
    chk("R8 bus free set", {7'b0, bus_free_o}, 8'h01);
    chk("R8 csr bit2", {7'b0, csr_o[2]}, 8'h01);
    wr(8'h10);
    chk("R9 bit2 not writable", {7'b0, csr_o[2]}, 8'h01);

    // R9: clears when either line drops
    sda_in = 1'b0; idle(4);
    chk("R9 clear on SDA low", {7'b0, bus_free_o}, 8'h00);
    sda_in = 1'b1; idle(30);
    chk("R9 free again", {7'b0, bus_free_o}, 8'h01);
    scl_in = 1'b0; idle(4);
    chk("R9 clear on SCL low", {7'b0, bus_free_o}, 8'h00);
    scl_in = 1'b1; idle(5);

    done = 1;
    wrap_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      applied++;
      miscmp++;
      $display("FAIL watchdog actual=running expected=done");
      wrap_up();
    end
  end
endmodule